// File: doc/BRIEF.md
# Pipelined Bus Slave SRAM Controller

This block sits between a pipelined system bus and a synchronous single-port SRAM. On the bus side it sees an address phase (address, direction flag and a valid qualifier). For writes, the address phase is followed one cycle later by a data phase that carries the write data. It answers with read data and a ready flag. On the memory side it drives address, data in, chip select and write enable, and it takes back the memory's registered data output.

A read is sent to the SRAM in its own address phase, so the memory output arrives exactly in the read's data phase. A write cannot be sent that early because its data is not yet on the bus. The controller therefore holds the write address for one cycle and commits the write during the data phase.

A read that arrives while a write is being committed would need the single port in the same cycle. In that case the controller pulls ready low for one cycle and starts the read in the next cycle. Cycles without a valid transfer produce no memory access, apart from the commit of a write that is already held.

Top module: `sram_slave_ctrl`

## Requirements
- R1: After synchronous reset, no write is held. While the bus is idle, ready is 1, chip select is 0, write enable is 0 and read data is 0.
- R2: Suppose an address phase has valid=1, write=0 and ready=1. In that same cycle the memory sees chip select 1, write enable 0 and the bus address.
- R3: In the cycle after an accepted read address phase, the bus read data equals the memory data output, which is the word stored at that address.
- R4: In the cycle after an accepted write address phase, the memory sees chip select 1 and write enable 1. Its address is the one captured in the address phase, and its data in is the bus write data of the current cycle.
- R5: A cycle with valid=0 that is not the data phase of a write causes no memory access (chip select 0).
- R6: Suppose a read address phase falls in the first data-phase cycle of a write. Ready is then 0 in that cycle, and the only memory access is the write commit.
- R7: Ready is never 0 for two cycles in a row. The held read is issued in the cycle after the stall, and its data comes back one cycle later.
- R8: Write address phases are always accepted with ready 1. Back-to-back writes, and a write directly after a read, are committed in order without a stall.
- R9: Bus read data is 0 in every cycle that is not the data phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and SRAM |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Address phase carries a transfer |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address of the address phase |
| bus_wdata | input | DATA_W | Write data, one cycle after its address |
| bus_rdata | output | DATA_W | Read data in the read data phase |
| bus_ready | output | 1 | 0 stretches the current data phase by one cycle |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_din | output | DATA_W | SRAM write data |
| sram_cs | output | 1 | SRAM chip select |
| sram_we | output | 1 | SRAM write enable (1 = write) |
| sram_dout | input | DATA_W | SRAM registered read data |

## Verification
Two functions can land in the same cycle: the commit of a held write and the issue of a newly arriving read. Both want the single memory port. The bench provokes this by placing a read of every address directly behind a write to that same address. It expects ready low for that one cycle, a commit with write enable 1, a read issued in the next cycle, and read data equal to the freshly written word. Write-after-read and write-after-write pairs over every address confirm that no stall appears where the port is free.

// File: rtl/sram_slave_pkg.sv
package sram_slave_pkg;

  // What the single SRAM port does in a given cycle
  typedef enum logic [1:0] {
    PORT_IDLE   = 2'd0,
    PORT_READ   = 2'd1,
    PORT_COMMIT = 2'd2
  } port_op_e;

endpackage

// File: rtl/ssc_write_hold.sv
// Holds the address of an accepted write until its data phase commits it.
module ssc_write_hold #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic              pend,
  output logic [ADDR_W-1:0] pend_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_addr <= '0;
    end else if (capture) begin
      // a new write address phase wins over retiring the previous one
      pend      <= 1'b1;
      pend_addr <= cap_addr;
    end else begin
      // a held write always commits in the cycle it is pending
      pend      <= 1'b0;
    end
  end

endmodule

// File: rtl/ssc_port_sel.sv
// Decides per cycle who owns the SRAM port and whether the bus must wait.
module ssc_port_sel
  import sram_slave_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              pend,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              ready,
  output logic              rd_issue,
  output logic              wr_capture,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_din,
  output logic              sram_cs,
  output logic              sram_we
);

  port_op_e op;
  logic     rd_req;

  assign rd_req     = bus_valid & ~bus_write;
  assign ready      = ~(pend & rd_req);
  assign rd_issue   = rd_req & ~pend;
  assign wr_capture = bus_valid & bus_write;

  always_comb begin
    if (pend)          op = PORT_COMMIT;
    else if (rd_issue) op = PORT_READ;
    else               op = PORT_IDLE;
  end

  always_comb begin
    sram_cs   = 1'b0;
    sram_we   = 1'b0;
    sram_addr = bus_addr;
    unique case (op)
      PORT_COMMIT: begin
        sram_cs   = 1'b1;
        sram_we   = 1'b1;
        sram_addr = pend_addr;
      end
      PORT_READ: sram_cs = 1'b1;
      default: ;
    endcase
  end

  assign sram_din = bus_wdata;

endmodule

// File: rtl/ssc_read_return.sv
// Tracks the read data phase and gates the SRAM output onto the bus.
module ssc_read_return #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] sram_dout,
  output logic [DATA_W-1:0] bus_rdata
);

  logic rd_phase;

  always_ff @(posedge clk) begin
    if (rst) rd_phase <= 1'b0;
    else     rd_phase <= rd_issue;
  end

  assign bus_rdata = rd_phase ? sram_dout : '0;

endmodule

// File: rtl/sram_slave_ctrl.sv
module sram_slave_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_din,
  output logic              sram_cs,
  output logic              sram_we,
  input  logic [DATA_W-1:0] sram_dout
);

  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  logic              rd_issue;
  logic              wr_capture;

  ssc_write_hold #(.ADDR_W(ADDR_W)) i_hold (
    .clk       (clk),
    .rst       (rst),
    .capture   (wr_capture),
    .cap_addr  (bus_addr),
    .pend      (pend),
    .pend_addr (pend_addr)
  );

  ssc_port_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sel (
    .pend       (pend),
    .pend_addr  (pend_addr),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ready      (bus_ready),
    .rd_issue   (rd_issue),
    .wr_capture (wr_capture),
    .sram_addr  (sram_addr),
    .sram_din   (sram_din),
    .sram_cs    (sram_cs),
    .sram_we    (sram_we)
  );

  ssc_read_return #(.DATA_W(DATA_W)) i_ret (
    .clk       (clk),
    .rst       (rst),
    .rd_issue  (rd_issue),
    .sram_dout (sram_dout),
    .bus_rdata (bus_rdata)
  );

endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_din,
  input logic              sram_cs,
  input logic              sram_we,
  input logic [DATA_W-1:0] sram_dout
);

  logic rd_acc;
  logic wr_acc;
  assign rd_acc = bus_valid & ~bus_write & bus_ready;
  assign wr_acc = bus_valid & bus_write & bus_ready;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    ($past(rst) && !rst && !bus_valid) |-> (!sram_cs && bus_ready && bus_rdata == '0));

  // R2
  read_issue_chk: assert property (@(posedge clk) disable iff (rst)
    rd_acc |-> (sram_cs && !sram_we && sram_addr == bus_addr));

  // R3
  read_return_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_acc && !rst) |-> (bus_rdata == sram_dout));

  // R4
  write_commit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_acc && !rst) |-> (sram_cs && sram_we && sram_addr == $past(bus_addr)
                               && sram_din == bus_wdata));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_valid && !$past(wr_acc && !rst)) |-> !sram_cs);

  // R6
  port_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_acc && !rst) && bus_valid && !bus_write) |-> (!bus_ready && sram_we));

  // R7
  single_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |=> bus_ready);

  // R8
  write_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write) |-> bus_ready);

  // R9
  rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_acc && !rst) |-> (bus_rdata == '0));

endmodule

bind sram_slave_ctrl ssc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ssc_checker (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_ready (bus_ready),
  .sram_addr (sram_addr),
  .sram_din  (sram_din),
  .sram_cs   (sram_cs),
  .sram_we   (sram_we),
  .sram_dout (sram_dout)
);

// File: tb/test_sram_slave_ctrl.sv
`timescale 1ns/1ps
module test_sram_slave_ctrl;

  localparam int AW    = 5;
  localparam int DW    = 16;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr  = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_ready;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_din;
  logic          sram_cs;
  logic          sram_we;
  logic [DW-1:0] sram_dout;

  always #4 clk = ~clk;

  sram_slave_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_sram_slave_ctrl (
    .clk (clk), .rst (rst),
    .bus_valid (bus_valid), .bus_write (bus_write), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_ready (bus_ready),
    .sram_addr (sram_addr), .sram_din (sram_din), .sram_cs (sram_cs),
    .sram_we (sram_we), .sram_dout (sram_dout)
  );

  // synchronous SRAM model: write on cs&we, registered read on cs&!we
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] dout_q = '0;
  always @(posedge clk) begin
    if (sram_cs && sram_we)  mem[sram_addr] <= sram_din;
    if (sram_cs && !sram_we) dout_q <= mem[sram_addr];
  end
  assign sram_dout = dout_q;

  int vectors = 0;
  int errors  = 0;
  logic [DW-1:0] model [WORDS];

  // bench-side view of the data phase in flight
  logic          dp_valid = 1'b0, dp_write = 1'b0, dp_stalled = 1'b0;
  logic [AW-1:0] dp_addr  = '0;
  logic [DW-1:0] dp_wdata = '0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 16'h3B1 + k * 16'h1D7 + 16'h0A5) & 16'hFFFF);
  endfunction

  // one bus address phase, repeated while the bench expects a stall
  task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    logic done = 1'b0;
    logic exp_commit, exp_ready, exp_read;
    logic [DW-1:0] exp_rd;
    while (!done) begin
      @(posedge clk); #1;
      bus_valid = v; bus_write = w; bus_addr = a;
      bus_wdata = (dp_valid && dp_write) ? dp_wdata : '0;
      @(negedge clk);
      exp_commit = dp_valid && dp_write && !dp_stalled;
      exp_ready  = !(exp_commit && v && !w);
      exp_read   = v && !w && exp_ready;
      exp_rd     = (dp_valid && !dp_write) ? model[dp_addr] : '0;
      if (!exp_ready)      chk(bus_ready == 1'b0, "R6 ready", 32'(bus_ready), 0);
      else if (dp_stalled) chk(bus_ready == 1'b1, "R7 ready", 32'(bus_ready), 1);
      else                 chk(bus_ready == 1'b1, "R8 ready", 32'(bus_ready), 1);
      if (exp_commit) begin
        chk(sram_cs && sram_we, "R4 cs/we", {sram_cs, sram_we}, 32'h3);
        chk(sram_addr == dp_addr, "R4 addr", 32'(sram_addr), 32'(dp_addr));
        chk(sram_din == dp_wdata, "R4 din", 32'(sram_din), 32'(dp_wdata));
      end else if (exp_read) begin
        chk(sram_cs && !sram_we, dp_stalled ? "R7 cs/we" : "R2 cs/we",
            {sram_cs, sram_we}, 32'h2);
        chk(sram_addr == a, "R2 addr", 32'(sram_addr), 32'(a));
      end else begin
        chk(!sram_cs, "R5 cs", 32'(sram_cs), 0);
      end
      chk(bus_rdata == exp_rd, (dp_valid && !dp_write) ? "R3 rdata" : "R9 rdata",
          32'(bus_rdata), 32'(exp_rd));
      if (exp_ready) begin
        if (dp_valid && dp_write) model[dp_addr] = dp_wdata;
        dp_valid = v; dp_write = w; dp_addr = a; dp_wdata = d; dp_stalled = 1'b0;
        done = 1'b1;
      end else begin
        dp_stalled = 1'b1;
      end
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin mem[i] = '0; model[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state with an idle bus
    chk(bus_ready == 1'b1, "R1 ready", 32'(bus_ready), 1);
    chk(!sram_cs && !sram_we, "R1 cs/we", {sram_cs, sram_we}, 0);
    chk(bus_rdata == '0, "R1 rdata", 32'(bus_rdata), 0);

    // R8: back-to-back writes over every address
    for (int a = 0; a < WORDS; a++) step(1'b1, 1'b1, AW'(a), pat(a, 1));
    step(1'b0, 1'b0, '0, '0);
    // R2/R3: back-to-back reads over every address
    for (int a = 0; a < WORDS; a++) step(1'b1, 1'b0, AW'(a), '0);
    step(1'b0, 1'b0, '0, '0);
    // R6/R7: read directly behind a write to the same address
    for (int a = 0; a < WORDS; a++) begin
      step(1'b1, 1'b1, AW'(a), pat(a, 2));
      step(1'b1, 1'b0, AW'(a), '0);
    end
    // R8: write directly behind a read, then read back
    for (int a = 0; a < WORDS; a++) begin
      step(1'b1, 1'b0, AW'(a), '0);
      step(1'b1, 1'b1, AW'(a), pat(a, 3));
      step(1'b1, 1'b0, AW'((a + 1) % WORDS), '0);
    end
    // R5: idle gaps between writes and reads
    for (int a = 0; a < WORDS; a++) begin
      step(1'b1, 1'b1, AW'(WORDS - 1 - a), pat(a, 4));
      step(1'b0, 1'b1, AW'(a), '0);
      step(1'b0, 1'b0, '0, '0);
      step(1'b1, 1'b0, AW'(WORDS - 1 - a), '0);
    end
    step(1'b0, 1'b0, '0, '0);
    step(1'b0, 1'b0, '0, '0);
    finish_run();
  end

endmodule